// File: doc/BRIEF.md
# Instruction Length Prefix Decoder

This block inspects the first few bits of an instruction held in a left-aligned fetch window and reports its length class. It covers 48, 64, 80 and 96 bits, and it folds everything of 32 bits or shorter into one "short" class. The length is carried in a prefix whose marker field grows with the instruction's size. A mode input selects one of two prefix sets for the two longest classes: the standard set or the CISC set. A prefix that begins a long-instruction marker but does not complete a legal one raises an illegal flag instead of a length.

Bit 0 of the window is the first instruction bit in fetch order. Only the first nine bits take part in the decision. A fetch or alignment stage uses the result to find where the next instruction starts. The decode is purely combinational. A parameter can add one output register stage.

Below, a prefix is written as a bit string in fetch order: the leftmost character is window bit 0.

Top module: `ilen_decoder`

## Requirements
- R1: In standard mode, when window bits 0..2 are not the string 110, the length code is 5'b00001 (short, 32 bits or less) unless R9 applies.
- R2: In either mode, a prefix 110 followed by any two bits other than 11 gives length code 5'b00010 (48 bits).
- R3: In either mode, the prefix 110110 gives length code 5'b00100 (64 bits).
- R4: In standard mode, the prefix 11011100 gives length code 5'b01000 (80 bits).
- R5: In standard mode, the prefix 110111100 gives length code 5'b10000 (96 bits).
- R6: In standard mode, a prefix starting 110111 that matches neither R4 nor R5 sets the illegal flag, with the length code 5'b00000.
- R7: In CISC mode, the prefix 11111110 gives 5'b01000 (80 bits) and 111111110 gives 5'b10000 (96 bits).
- R8: In CISC mode, any prefix starting 110111 and the prefix 111111111 set the illegal flag, with the length code 5'b00000.
- R9: The seven-ones prefix 1111111 is short (5'b00001) in standard mode. In CISC mode, a prefix that starts with neither 110 nor seven ones is short.
- R10: The output valid follows the input valid. While it is low, the length code and the illegal flag are zero. While it is high, exactly one of these holds: a single length bit is set, or the illegal flag is set.
- R11: With REG_OUT=1, every output appears exactly one clock after its input and reset clears all outputs. With REG_OUT=0, the outputs follow the inputs in the same cycle.
- R12: The mode is sampled together with the window it accompanies, so a mode change applies starting with the window presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset of the output stage |
| win_i | input | WIN_W | Fetch window, bit 0 first in fetch order |
| valid_i | input | 1 | Window holds an instruction start |
| cisc_i | input | 1 | 1 selects the CISC prefix set, 0 the standard set |
| len_o | output | 5 | One-hot length: bit0 short, bit1 48, bit2 64, bit3 80, bit4 96 |
| illegal_o | output | 1 | Prefix starts a long marker but is not a legal one |
| valid_o | output | 1 | Result valid |

## Verification
A mode switch and a new window can arrive in the same cycle. In that case the result must follow the new mode for the new window, not the previous mode. To provoke this, the bench holds the window 111111100 and flips the mode every cycle. In the registered build, the result for each cycle must read short, then 80 bits, then short, with each answer lagging its inputs by exactly one clock. The prefix 110111100 is also toggled between modes: it must alternate between 96 bits and illegal.

// File: rtl/ilen_pkg.sv
package ilen_pkg;
    localparam int PFX_W = 9;
    localparam int LEN_W = 5;

    typedef enum logic [2:0] {
        LC_SHORT = 3'd0,
        LC_48    = 3'd1,
        LC_64    = 3'd2,
        LC_80    = 3'd3,
        LC_96    = 3'd4,
        LC_BAD   = 3'd5
    } len_class_e;

    typedef struct packed {
        logic             vld;
        logic             bad;
        logic [LEN_W-1:0] len;
    } ilen_res_t;
endpackage

// File: rtl/ilen_std_match.sv
module ilen_std_match
    import ilen_pkg::*;
(
    input  logic [PFX_W-1:0] pfx_i,   // pfx_i[PFX_W-1] is the first fetched bit
    output len_class_e       cls_o
);
    always_comb begin
        priority casez (pfx_i)
            9'b110110???: cls_o = LC_64;
            9'b11011100?: cls_o = LC_80;
            9'b110111100: cls_o = LC_96;
            9'b110111???: cls_o = LC_BAD;
            9'b110??????: cls_o = LC_48;
            default:      cls_o = LC_SHORT;
        endcase
    end
endmodule

// File: rtl/ilen_cisc_match.sv
module ilen_cisc_match
    import ilen_pkg::*;
(
    input  logic [PFX_W-1:0] pfx_i,
    output len_class_e       cls_o
);
    always_comb begin
        priority casez (pfx_i)
            9'b110110???: cls_o = LC_64;
            9'b110111???: cls_o = LC_BAD;
            9'b110??????: cls_o = LC_48;
            9'b11111110?: cls_o = LC_80;
            9'b111111110: cls_o = LC_96;
            9'b111111111: cls_o = LC_BAD;
            default:      cls_o = LC_SHORT;
        endcase
    end
endmodule

// File: rtl/ilen_encode.sv
module ilen_encode
    import ilen_pkg::*;
(
    input  len_class_e cls_i,
    input  logic       valid_i,
    output ilen_res_t  res_o
);
    always_comb begin
        res_o     = '0;
        res_o.vld = valid_i;
        if (valid_i) begin
            unique case (cls_i)
                LC_SHORT: res_o.len = 5'b00001;
                LC_48:    res_o.len = 5'b00010;
                LC_64:    res_o.len = 5'b00100;
                LC_80:    res_o.len = 5'b01000;
                LC_96:    res_o.len = 5'b10000;
                LC_BAD:   res_o.bad = 1'b1;
                default:  res_o.bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ilen_out_stage.sv
module ilen_out_stage
    import ilen_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  ilen_res_t res_i,
    output ilen_res_t res_o
);
    generate
        if (REG_OUT) begin : g_reg
            ilen_res_t res_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) res_q <= '0;
                else         res_q <= res_i;
            end
            assign res_o = res_q;
        end else begin : g_pass
            logic unused_clk;
            assign unused_clk = clk_i ^ rst_ni;
            assign res_o      = res_i;
        end
    endgenerate
endmodule

// File: rtl/ilen_decoder.sv
module ilen_decoder
    import ilen_pkg::*;
#(
    parameter int WIN_W   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIN_W-1:0] win_i,
    input  logic             valid_i,
    input  logic             cisc_i,
    output logic [LEN_W-1:0] len_o,
    output logic             illegal_o,
    output logic             valid_o
);
    logic [PFX_W-1:0] pfx;
    len_class_e       cls_std, cls_cisc, cls_sel;
    ilen_res_t        res_comb, res_out;
    logic             unused_tail;

    // Reverse into fetch order so patterns read left to right.
    for (genvar i = 0; i < PFX_W; i++) begin : g_pfx
        assign pfx[PFX_W-1-i] = win_i[i];
    end
    assign unused_tail = ^win_i[WIN_W-1:PFX_W];

    ilen_std_match  u_std  (.pfx_i(pfx), .cls_o(cls_std));
    ilen_cisc_match u_cisc (.pfx_i(pfx), .cls_o(cls_cisc));

    assign cls_sel = cisc_i ? cls_cisc : cls_std;

    ilen_encode u_enc (.cls_i(cls_sel), .valid_i(valid_i), .res_o(res_comb));

    ilen_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .res_i (res_comb),
        .res_o (res_out)
    );

    assign len_o     = res_out.len;
    assign illegal_o = res_out.bad;
    assign valid_o   = res_out.vld;
endmodule

// File: rtl/ilen_decoder_chk.sv
module ilen_decoder_chk
    import ilen_pkg::*;
#(
    parameter int WIN_W   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [WIN_W-1:0] win_i,
    input logic             valid_i,
    input logic             cisc_i,
    input logic [LEN_W-1:0] len_o,
    input logic             illegal_o,
    input logic             valid_o
);
    logic std_short;
    assign std_short = valid_i && !cisc_i && !(win_i[0] && win_i[1] && !win_i[2])
                       && !(&win_i[6:0]);

    AST_LEN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(len_o)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (len_o == '0 && !illegal_o)); // R10
    AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (($countones(len_o) == 1) != illegal_o)); // R10

    generate
        if (REG_OUT) begin : g_reg_chk
            AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
                valid_i |=> valid_o); // R11
            AST_IDLE_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !valid_i |=> !valid_o); // R11
            AST_STD_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                std_short |=> len_o[0]); // R1
        end else begin : g_comb_chk
            AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
                valid_o == valid_i); // R11
            AST_STD_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                std_short |-> len_o[0]); // R1
        end
    endgenerate
endmodule

bind ilen_decoder ilen_decoder_chk #(.WIN_W(WIN_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/ilen_decoder_test.sv
module ilen_decoder_test;
    localparam int WIN_W = 32;
    localparam int NV    = 24;

    // {cisc, prefix[8:0] in fetch order (MSB first), len[4:0], illegal}
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 9'b000000000, 5'b00001, 1'b0},
        {1'b0, 9'b101111111, 5'b00001, 1'b0},
        {1'b0, 9'b111111110, 5'b00001, 1'b0},
        {1'b0, 9'b110000000, 5'b00010, 1'b0},
        {1'b0, 9'b110011111, 5'b00010, 1'b0},
        {1'b0, 9'b110100101, 5'b00010, 1'b0},
        {1'b0, 9'b110110000, 5'b00100, 1'b0},
        {1'b0, 9'b110110111, 5'b00100, 1'b0},
        {1'b0, 9'b110111000, 5'b01000, 1'b0},
        {1'b0, 9'b110111001, 5'b01000, 1'b0},
        {1'b0, 9'b110111100, 5'b10000, 1'b0},
        {1'b0, 9'b110111101, 5'b00000, 1'b1},
        {1'b0, 9'b110111110, 5'b00000, 1'b1},
        {1'b0, 9'b110111010, 5'b00000, 1'b1},
        {1'b0, 9'b110111111, 5'b00000, 1'b1},
        {1'b1, 9'b111111100, 5'b01000, 1'b0},
        {1'b1, 9'b111111101, 5'b01000, 1'b0},
        {1'b1, 9'b111111110, 5'b10000, 1'b0},
        {1'b1, 9'b111111111, 5'b00000, 1'b1},
        {1'b1, 9'b110111100, 5'b00000, 1'b1},
        {1'b1, 9'b110110000, 5'b00100, 1'b0},
        {1'b1, 9'b110010000, 5'b00010, 1'b0},
        {1'b1, 9'b111111011, 5'b00001, 1'b0},
        {1'b1, 9'b011111111, 5'b00001, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIN_W-1:0] win = '0;
    logic             vin = 1'b0;
    logic             cisc = 1'b0;
    logic [4:0]       len_r, len_c;
    logic             ill_r, ill_c, vo_r, vo_c;
    int               total = 0;
    int               bad = 0;
    bit               done = 1'b0;

    always #2 clk = ~clk;

    ilen_decoder #(.WIN_W(WIN_W), .REG_OUT(1'b1)) uut (
        .clk_i(clk), .rst_ni(rst_n), .win_i(win), .valid_i(vin), .cisc_i(cisc),
        .len_o(len_r), .illegal_o(ill_r), .valid_o(vo_r));

    ilen_decoder #(.WIN_W(WIN_W), .REG_OUT(1'b0)) uut_comb (
        .clk_i(clk), .rst_ni(rst_n), .win_i(win), .valid_i(vin), .cisc_i(cisc),
        .len_o(len_c), .illegal_o(ill_c), .valid_o(vo_c));

    function automatic logic [WIN_W-1:0] mk_win(input logic [8:0] p);
        logic [WIN_W-1:0] w = 32'hA5A5_A5A5;
        for (int i = 0; i < 9; i++) w[i] = p[8-i];
        return w;
    endfunction

    function automatic string tag_of(input logic m, input logic [8:0] p,
                                     input logic [4:0] l, input logic il);
        if (il) return m ? "R8" : "R6";
        unique case (l)
            5'b00010: return "R2";
            5'b00100: return "R3";
            5'b01000: return m ? "R7" : "R4";
            5'b10000: return m ? "R7" : "R5";
            default:  return (m || p[8:2] == 7'b1111111) ? "R9" : "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got {vld,ill,len}=%b expected %b", tag, act, exp);
        end
    endtask

    // Drive one window, check the combinational copy, then the registered copy.
    task automatic apply(input logic m, input logic v, input logic [8:0] p,
                         input logic [4:0] l, input logic il, input string tag);
        @(negedge clk);
        cisc = m; vin = v; win = mk_win(p);
        #1;
        check({tag, " comb"}, {vo_c, ill_c, len_c}, {v, il, l});
        @(posedge clk);
        #1;
        check({tag, " reg R11"}, {vo_r, ill_r, len_r}, {v, il, l});
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset", {vo_r, ill_r, len_r}, 7'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][15], 1'b1, VEC[k][14:6], VEC[k][5:1], VEC[k][0],
                  tag_of(VEC[k][15], VEC[k][14:6], VEC[k][5:1], VEC[k][0]));
        end

        // R10: invalid window produces nothing
        apply(1'b0, 1'b0, 9'b110110000, 5'b00000, 1'b0, "R10 idle");
        apply(1'b1, 1'b0, 9'b111111111, 5'b00000, 1'b0, "R10 idle bad");

        // R12: mode flipped every cycle with the same window
        @(negedge clk);
        vin = 1'b1; win = mk_win(9'b111111100); cisc = 1'b0;
        @(negedge clk);
        check("R12 std first", {vo_r, ill_r, len_r}, {1'b1, 1'b0, 5'b00001});
        cisc = 1'b1;
        #1;
        check("R12 comb cisc", {vo_c, ill_c, len_c}, {1'b1, 1'b0, 5'b01000});
        @(negedge clk);
        check("R12 cisc next", {vo_r, ill_r, len_r}, {1'b1, 1'b0, 5'b01000});
        cisc = 1'b0;
        @(negedge clk);
        check("R12 std back", {vo_r, ill_r, len_r}, {1'b1, 1'b0, 5'b00001});
        win = mk_win(9'b110111100); cisc = 1'b1;
        @(negedge clk);
        check("R12 R8 bad", {vo_r, ill_r, len_r}, {1'b1, 1'b1, 5'b00000});
        cisc = 1'b0;
        @(negedge clk);
        check("R12 R5 96", {vo_r, ill_r, len_r}, {1'b1, 1'b0, 5'b10000});

        // R11: reset in mid-stream clears the registered result
        rst_n = 1'b0;
        #1;
        check("R11 mid reset", {vo_r, ill_r, len_r}, 7'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule